// File: doc/BRIEF.md
# Receive character buffer with idle timeout

This block sits between a serial receiver's shift register and the register interface that software reads. Every time the receiver finishes a character it raises a one-cycle load strobe with the raw nine received bits, a parity-error flag and a framing-error flag. The block turns these into a 10-bit stored entry whose layout depends on the frame format. In wake-up mode it throws away characters whose ninth bit is clear. It keeps the entries in a 16-slot FIFO, or in a single slot when FIFO operation is switched off.

Software sees the oldest entry on `rd_data` and removes it with a one-cycle read strobe. The status outputs show whether the buffer holds anything, whether it is more than half full, whether a character was lost, and whether any held entry carries a parity error. An 8-bit idle counter reloads from a programmable value whenever a read happens, a character is in progress or the value is written. Otherwise it counts down on baud ticks and stops at zero. A timeout flag is raised while the counter is at zero and data is waiting.

Control is an occupancy state machine with three states. S_EMPTY holds no entry. S_HOLD holds at least one entry and has room for more. S_FULL holds as many entries as the current mode allows. Each clock it steps to the state that matches the occupancy after that cycle's reset, pop and accept. A reset strobe moves any state to S_EMPTY. An accept without a pop leads from S_EMPTY, or on from S_HOLD, to S_HOLD or S_FULL. A pop without an accept leads from S_FULL or S_HOLD down to S_HOLD or S_EMPTY. A pop and an accept in the same cycle keep the state. A load in S_FULL with no read sets overrun and leaves the state as it is.

Top module: `rx_char_buffer`

## Requirements
- R1: A stored entry is built from the inputs according to `frame_fmt`. For 0 (8 data, no parity) it is {fe, 0, d[7:0]}. For 1 (8 data + parity) it is {fe, pe, d[7:0]}. For 2 (7 data + parity) it is {fe, pe, pe, d[6:0]}. For 3 (9 data) it is {fe, d[8:0]}. Here fe is bit 9, pe is the parity-error flag and d is `rx_bits`.
- R2: While `wake_mode` is 1, a loaded character whose `rx_bits[8]` is 0 is discarded, and one whose `rx_bits[8]` is 1 is stored.
- R3: With `fifo_en`=1, up to 16 entries are kept and read back oldest first. `buf_full` is 1 while at least one entry is held. `half_full` is 1 while more than 8 entries are held.
- R4: With `fifo_en`=0, the buffer holds at most one entry.
- R5: A `rx_clr` pulse empties the buffer. It takes priority over a load or read in the same cycle, and a load in that cycle is lost.
- R6: A load while the buffer is full, with no read in the same cycle, sets `overrun`, drops the new character and leaves the stored entries unchanged. Any read strobe clears `overrun`.
- R7: `parity_err` is 1 while any held entry has bit 8 set.
- R8: While empty, `rd_data` is 0. A read of an empty buffer changes no entry and no pointer.
- R9: `tmo_count` reloads from the timeout value when `rd_strobe`, `rx_busy` or `tmo_wr` is 1. On `tmo_wr` the new value `tmo_value` is loaded and kept for later reloads.
- R10: When no reload condition holds, `tmo_count` decrements by one on each `baud_tick` and stays at 0 once it reaches 0.
- R11: `timeout` is 1 exactly when `tmo_count` is 0 and the buffer is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects the 16-entry FIFO, 0 selects the single buffer |
| frame_fmt | input | 2 | Frame format code (see R1) |
| wake_mode | input | 1 | Store only characters with bit 8 set |
| rx_load | input | 1 | One-cycle strobe: a character is complete |
| rx_bits | input | 9 | Raw received bits |
| rx_perr | input | 1 | Parity error of the completed character |
| rx_ferr | input | 1 | Framing error of the completed character |
| rx_busy | input | 1 | A character is being received |
| rx_clr | input | 1 | Strobe that empties the buffer |
| rd_strobe | input | 1 | Read of the data register; pops the oldest entry |
| tmo_wr | input | 1 | Write strobe for the timeout value |
| tmo_value | input | 8 | New timeout value |
| baud_tick | input | 1 | Baud-rate tick |
| rd_data | output | 10 | Oldest held entry, zero when empty |
| buf_full | output | 1 | At least one entry held |
| half_full | output | 1 | More than 8 entries held |
| overrun | output | 1 | A character was lost to a full buffer |
| parity_err | output | 1 | A held entry has a parity error |
| timeout | output | 1 | Counter at zero with data waiting |
| tmo_count | output | 8 | Current timeout counter value |

## Verification
The checks take for granted that `fifo_en` changes only in a cycle where `rx_clr` is also pulsed, so the occupancy never exceeds the capacity of the mode in force. The bench always changes `fifo_en` inside the same cycle as its clear pulse. Strobes are taken to be one cycle wide and sampled on the rising edge. The bench drives every input just after a falling edge and holds each strobe for exactly one clock.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int ENTRY_W = 10;
    localparam int RAW_W   = 9;

    typedef enum logic [1:0] {
        FMT_8N = 2'd0,
        FMT_8P = 2'd1,
        FMT_7P = 2'd2,
        FMT_9B = 2'd3
    } frame_fmt_t;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_HOLD  = 2'd1,
        S_FULL  = 2'd2
    } occ_state_t;
endpackage

// File: rtl/rxb_format.sv
module rxb_format
    import rxb_pkg::*;
(
    input  logic [1:0]         fmt,
    input  logic               wake,
    input  logic               load,
    input  logic [RAW_W-1:0]   bits,
    input  logic               perr,
    input  logic               ferr,
    output logic [ENTRY_W-1:0] entry,
    output logic               keep
);
    always_comb begin
        unique case (frame_fmt_t'(fmt))
            FMT_8N:  entry = {ferr, 1'b0, bits[7:0]};
            FMT_8P:  entry = {ferr, perr, bits[7:0]};
            FMT_7P:  entry = {ferr, perr, perr, bits[6:0]};
            FMT_9B:  entry = {ferr, bits[8:0]};
            default: entry = '0;
        endcase
    end

    // wake-up filtering looks at the raw ninth bit
    assign keep = load && (!wake || bits[8]);
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             clr,
    input  logic             load,
    input  logic             rd,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic             pop,
    output logic [PTR_W-1:0] rd_idx,
    output logic [OCC_W-1:0] occ,
    output logic             ovr,
    output occ_state_t       state
);
    localparam logic [OCC_W-1:0] CAP_FIFO = OCC_W'(DEPTH);
    localparam logic [OCC_W-1:0] CAP_ONE  = OCC_W'(1);

    occ_state_t       state_q, state_n;
    logic [OCC_W-1:0] occ_q, occ_n;
    logic [PTR_W-1:0] wp_q, rp_q;
    logic             ovr_q;
    logic [OCC_W-1:0] cap;
    logic             accept, do_pop, drop;

    assign cap = fifo_en ? CAP_FIFO : CAP_ONE;

    // decide pop / accept / drop from the current occupancy state
    always_comb begin
        do_pop = 1'b0;
        accept = 1'b0;
        drop   = 1'b0;
        if (!clr) begin
            unique case (state_q)
                S_EMPTY: begin
                    accept = load;
                end
                S_HOLD: begin
                    do_pop = rd;
                    accept = load;
                end
                S_FULL: begin
                    do_pop = rd;
                    accept = load && rd;
                    drop   = load && !rd;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (clr)
            occ_n = '0;
        else
            occ_n = occ_q + (accept ? CAP_ONE : '0) - (do_pop ? CAP_ONE : '0);
        if (occ_n == '0)
            state_n = S_EMPTY;
        else if (occ_n >= cap)
            state_n = S_FULL;
        else
            state_n = S_HOLD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_EMPTY;
        else
            state_q <= state_n;
    end

    // counters, pointers and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
            ovr_q <= 1'b0;
        end else begin
            occ_q <= occ_n;
            if (clr) begin
                wp_q <= '0;
                rp_q <= '0;
            end else begin
                if (accept)
                    wp_q <= fifo_en ? wp_q + PTR_W'(1) : '0;
                if (do_pop)
                    rp_q <= fifo_en ? rp_q + PTR_W'(1) : '0;
            end
            if (rd)
                ovr_q <= 1'b0;
            else if (drop)
                ovr_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_en  = accept;
        pop    = do_pop;
        wr_idx = fifo_en ? wp_q : '0;
        rd_idx = fifo_en ? rp_q : '0;
        occ    = occ_q;
        ovr    = ovr_q;
        state  = state_q;
    end
endmodule

// File: rtl/rxb_store.sv
module rxb_store
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               pop,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] head,
    output logic               any_perr
);
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]   valid;
    logic [DEPTH-1:0]   perr_vec;

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (clr) begin
            valid <= '0;
        end else begin
            if (pop)
                valid[rd_idx] <= 1'b0;
            if (wr_en)
                valid[wr_idx] <= 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_perr
            assign perr_vec[i] = valid[i] && mem[i][8];
        end
    endgenerate

    assign any_perr = |perr_vec;
    assign head     = valid[rd_idx] ? mem[rd_idx] : '0;
endmodule

// File: rtl/rxb_timer.sv
module rxb_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             rd,
    input  logic             busy,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] reload_q, cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (wr) begin
                reload_q <= wr_val;
                cnt_q    <= wr_val;
            end else if (rd || busy) begin
                cnt_q <= reload_q;
            end else if (tick && cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TMO_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int HALF  = DEPTH / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic [1:0]         frame_fmt,
    input  logic               wake_mode,
    input  logic               rx_load,
    input  logic [RAW_W-1:0]   rx_bits,
    input  logic               rx_perr,
    input  logic               rx_ferr,
    input  logic               rx_busy,
    input  logic               rx_clr,
    input  logic               rd_strobe,
    input  logic               tmo_wr,
    input  logic [TMO_W-1:0]   tmo_value,
    input  logic               baud_tick,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               buf_full,
    output logic               half_full,
    output logic               overrun,
    output logic               parity_err,
    output logic               timeout,
    output logic [TMO_W-1:0]   tmo_count
);
    logic [ENTRY_W-1:0] entry;
    logic               keep;
    logic               wr_en, pop;
    logic [PTR_W-1:0]   wr_idx, rd_idx;
    logic [OCC_W-1:0]   occ;
    occ_state_t         state;

    rxb_format u_fmt (
        .fmt   (frame_fmt),
        .wake  (wake_mode),
        .load  (rx_load),
        .bits  (rx_bits),
        .perr  (rx_perr),
        .ferr  (rx_ferr),
        .entry (entry),
        .keep  (keep)
    );

    rxb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .clr     (rx_clr),
        .load    (keep),
        .rd      (rd_strobe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .pop     (pop),
        .rd_idx  (rd_idx),
        .occ     (occ),
        .ovr     (overrun),
        .state   (state)
    );

    rxb_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (entry),
        .pop      (pop),
        .rd_idx   (rd_idx),
        .head     (rd_data),
        .any_perr (parity_err)
    );

    rxb_timer #(.CNT_W(TMO_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (tmo_wr),
        .wr_val (tmo_value),
        .rd     (rd_strobe),
        .busy   (rx_busy),
        .tick   (baud_tick),
        .count  (tmo_count)
    );

    assign buf_full  = (state != S_EMPTY);
    assign half_full = (occ > OCC_W'(HALF));
    assign timeout   = buf_full && (tmo_count == '0);
endmodule

// File: rtl/rx_char_buffer_chk.sv
module rx_char_buffer_chk #(
    parameter int DEPTH = 16,
    parameter int TMO_W = 8,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             rx_load,
    input logic             rx_clr,
    input logic             rd_strobe,
    input logic             rx_busy,
    input logic             tmo_wr,
    input logic [TMO_W-1:0] tmo_value,
    input logic             baud_tick,
    input logic             buf_full,
    input logic             half_full,
    input logic             overrun,
    input logic             parity_err,
    input logic [TMO_W-1:0] tmo_count,
    input logic [OCC_W-1:0] occ
);
    p_fifo_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

    p_half_implies_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        half_full |-> buf_full);

    p_single_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !rx_clr) |-> (occ <= OCC_W'(1)));

    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> (!buf_full && !parity_err));

    p_overrun_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(rx_load) && !$past(rd_strobe)));

    p_overrun_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !overrun);

    p_tmo_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_wr |=> (tmo_count == $past(tmo_value)));

    p_tmo_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && !tmo_wr && !rd_strobe && !rx_busy && tmo_count != '0)
        |=> (tmo_count == $past(tmo_count) - TMO_W'(1)));

    p_tmo_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmo_wr && !rd_strobe && !rx_busy && tmo_count == '0)
        |=> (tmo_count == '0));
endmodule

bind rx_char_buffer rx_char_buffer_chk #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .rx_load    (rx_load),
    .rx_clr     (rx_clr),
    .rd_strobe  (rd_strobe),
    .rx_busy    (rx_busy),
    .tmo_wr     (tmo_wr),
    .tmo_value  (tmo_value),
    .baud_tick  (baud_tick),
    .buf_full   (buf_full),
    .half_full  (half_full),
    .overrun    (overrun),
    .parity_err (parity_err),
    .tmo_count  (tmo_count),
    .occ        (occ)
);

// File: tb/rx_char_buffer_test.sv
module rx_char_buffer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] frame_fmt = 2'd0;
    logic       wake_mode = 1'b0;
    logic       rx_load = 1'b0;
    logic [8:0] rx_bits = '0;
    logic       rx_perr = 1'b0;
    logic       rx_ferr = 1'b0;
    logic       rx_busy = 1'b0;
    logic       rx_clr = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       tmo_wr = 1'b0;
    logic [7:0] tmo_value = '0;
    logic       baud_tick = 1'b0;
    logic [9:0] rd_data;
    logic       buf_full, half_full, overrun, parity_err, timeout;
    logic [7:0] tmo_count;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_char_buffer uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .frame_fmt(frame_fmt),
        .wake_mode(wake_mode), .rx_load(rx_load), .rx_bits(rx_bits),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_busy(rx_busy),
        .rx_clr(rx_clr), .rd_strobe(rd_strobe), .tmo_wr(tmo_wr),
        .tmo_value(tmo_value), .baud_tick(baud_tick), .rd_data(rd_data),
        .buf_full(buf_full), .half_full(half_full), .overrun(overrun),
        .parity_err(parity_err), .timeout(timeout), .tmo_count(tmo_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [8:0] b, input logic pe, input logic fe);
        @(negedge clk);
        rx_bits = b; rx_perr = pe; rx_ferr = fe; rx_load = 1'b1;
        @(negedge clk);
        rx_load = 1'b0;
    endtask

    task automatic read(output logic [9:0] v);
        @(negedge clk);
        v = rd_data;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic clear(input logic fen);
        @(negedge clk);
        rx_clr = 1'b1; fifo_en = fen;
        @(negedge clk);
        rx_clr = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R8 reset rd_data", rd_data, 0);
        check("R3 reset buf_full", buf_full, 0);
        check("R6 reset overrun", overrun, 0);
        check("R11 reset timeout", timeout, 0);
        check("R9 reset count", tmo_count, 0);
    endtask

    task automatic t_formats;
        logic [9:0] v;
        clear(1'b1);
        frame_fmt = 2'd0; load(9'h1FF, 1'b1, 1'b1); read(v);
        check("R1 8N entry", v, 10'h2FF);
        frame_fmt = 2'd1; load(9'h025, 1'b1, 1'b0); read(v);
        check("R1 8P entry", v, 10'h125);
        frame_fmt = 2'd2; load(9'h025, 1'b1, 1'b0); read(v);
        check("R1 7P entry with error", v, 10'h1A5);
        frame_fmt = 2'd2; load(9'h0FF, 1'b0, 1'b0); read(v);
        check("R1 7P entry clean", v, 10'h07F);
        frame_fmt = 2'd3; load(9'h155, 1'b1, 1'b0); read(v);
        check("R1 9-bit entry", v, 10'h155);
    endtask

    task automatic t_wake;
        logic [9:0] v;
        frame_fmt = 2'd3; wake_mode = 1'b1;
        load(9'h0AA, 1'b0, 1'b0);
        check("R2 discard bit8=0", buf_full, 0);
        load(9'h1AA, 1'b0, 1'b0);
        check("R2 store bit8=1", buf_full, 1);
        read(v);
        check("R2 stored value", v, 10'h1AA);
        wake_mode = 1'b0;
    endtask

    task automatic t_fifo;
        logic [9:0] v;
        int bad = 0;
        frame_fmt = 2'd3;
        for (int i = 0; i < 16; i++) begin
            load(9'(i + 16), 1'b0, 1'b0);
            if (i == 7) check("R3 half_full at 8", half_full, 0);
            if (i == 8) check("R3 half_full at 9", half_full, 1);
        end
        check("R3 full after 16", buf_full, 1);
        check("R6 no overrun at 16", overrun, 0);
        load(9'h1EE, 1'b0, 1'b0);
        check("R6 overrun set", overrun, 1);
        for (int i = 0; i < 16; i++) begin
            read(v);
            if (i == 0) check("R6 overrun cleared by read", overrun, 0);
            if (v != 10'(i + 16)) bad++;
        end
        check("R3 order, R6 dropped char", bad, 0);
        check("R3 empty after drain", buf_full, 0);
    endtask

    task automatic t_single;
        logic [9:0] v;
        clear(1'b0);
        load(9'h011, 1'b0, 1'b0);
        load(9'h022, 1'b0, 1'b0);
        check("R4 second char overruns", overrun, 1);
        read(v);
        check("R4 keeps first", v, 10'h011);
        check("R4 empty after one read", buf_full, 0);
        clear(1'b1);
    endtask

    task automatic t_clear;
        load(9'h001, 1'b1, 1'b0);
        load(9'h002, 1'b0, 1'b0);
        clear(1'b1);
        check("R5 empty after clear", buf_full, 0);
        check("R5 rd_data after clear", rd_data, 0);
        @(negedge clk);
        rx_clr = 1'b1; rx_bits = 9'h033; rx_load = 1'b1;
        @(negedge clk);
        rx_clr = 1'b0; rx_load = 1'b0;
        check("R5 clear beats load", buf_full, 0);
    endtask

    task automatic t_parity;
        logic [9:0] v;
        frame_fmt = 2'd1;
        load(9'h041, 1'b0, 1'b0);
        load(9'h042, 1'b1, 1'b0);
        load(9'h043, 1'b0, 1'b0);
        check("R7 parity set", parity_err, 1);
        read(v);
        check("R7 still held", parity_err, 1);
        read(v);
        check("R7 cleared after pop", parity_err, 0);
        read(v);
        check("R7 last value", v, 10'h043);
    endtask

    task automatic t_empty_read;
        logic [9:0] v;
        read(v);
        check("R8 empty read value", v, 0);
        check("R8 still empty", buf_full, 0);
        frame_fmt = 2'd3;
        load(9'h0C3, 1'b0, 1'b0);
        read(v);
        check("R8 pointers intact", v, 10'h0C3);
    endtask

    task automatic t_timer;
        logic [9:0] v;
        @(negedge clk); tmo_value = 8'd5; tmo_wr = 1'b1;
        @(negedge clk); tmo_wr = 1'b0;
        check("R9 write loads", tmo_count, 5);
        tick(3);
        check("R10 decrement", tmo_count, 2);
        @(negedge clk); rx_busy = 1'b1; baud_tick = 1'b1;
        @(negedge clk); rx_busy = 1'b0; baud_tick = 1'b0;
        check("R9 busy reloads", tmo_count, 5);
        tick(2);
        read(v);
        check("R9 read reloads", tmo_count, 5);
        tick(6);
        check("R10 floor at zero", tmo_count, 0);
        check("R11 no timeout when empty", timeout, 0);
        load(9'h055, 1'b0, 1'b0);
        check("R11 timeout with data", timeout, 1);
        read(v);
        check("R11 cleared by read", timeout, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_formats();
        t_wake();
        t_fifo();
        t_single();
        t_clear();
        t_parity();
        t_empty_read();
        t_timer();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule